// File: doc/BRIEF.md
# Bus Write-Hit Test Target

A small bus peripheral that lets a host confirm that byte writes reach the intended address in two separate windows: a 4096-byte memory window and a 256-byte I/O window. The host arms one of a fixed table of tests by writing a kind number to byte 0 of either window. The window used and the kind number together pick the table entry. The armed entry fixes a trigger address and a rule for which writes count. Every qualifying write to the trigger address adds one to a 32-bit hit counter.

The host reads a 14-byte little-endian header of the armed test through the same byte-wide bus. Reads are combinational on the address. Bytes 0–3 hold the armed table index. Bytes 4–7 hold the trigger address. Byte 8 holds the expected data byte. Byte 9 holds the access width. Bytes 10–13 hold the hit counter. With three test kinds and two windows the table has six entries. Kind 1 is the wildcard kind. Kinds 0 and 2 match on data.

Top module: `wr_hit_target`

## Requirements
- R1: A write with `bus_addr` = 0 is a select write in either window. `bus_io` = 0 marks the memory window and `bus_io` = 1 the I/O window. A hit depends only on `bus_addr`, not on which window the write arrives through.
- R2: A select write with data below 3 arms the entry with index `bus_io`×3 + data. Header bytes 0–3 then read that index, little-endian.
- R3: A select write with data of 3 or more leaves no test armed.
- R4: Arming any entry clears the hit counter to zero.
- R5: Entry i has trigger address region + i, where region is 2048 for entries 0–2 and 128 for entries 3–5. Header bytes 4–7 read the trigger address, little-endian.
- R6: For kinds 0 and 2, header byte 8 reads 0xFA. A write to the trigger address counts only if `bus_len` = 1 and the data byte is 0xFA.
- R7: For kind 1, header byte 8 reads 0xCE, and every write to the trigger address counts whatever its data or length.
- R8: While a test is armed, a write to any address other than 0 or the trigger address leaves the counter unchanged.
- R9: While no test is armed, non-select writes have no effect and every read returns 0.
- R10: Header byte 9 reads 1. A read at address 14 or above returns 0.
- R11: Reset disarms the test and clears the counter.
- R12: Each counted write adds exactly 1 to the 32-bit counter, carrying across bytes 10–13, little-endian.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_io | input | 1 | Window of the access: 0 memory, 1 I/O |
| bus_addr | input | 12 | Byte offset within the window, for writes and reads |
| bus_len | input | 3 | Length in bytes of the access the write belongs to |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Header byte at `bus_addr` of the armed test |

## Verification
The assertions assume an I/O-window address never exceeds 255. They also assume `bus_wr` and the other bus inputs change only between clock edges, so each property can treat one cycle as one write. The stimulus drives every input at the falling edge. It keeps I/O offsets below 256 and performs reads with `bus_wr` low, because a read is only an address presented while no write is in progress. The sequences cover every kind in both windows, writes arriving through the opposite window, rejected data and lengths, and counter carries.

// File: rtl/wht_pkg.sv
package wht_pkg;
  localparam int KINDS      = 3;
  localparam int WINDOWS    = 2;
  localparam int TESTS      = KINDS * WINDOWS;
  localparam int IDX_W      = $clog2(TESTS);
  localparam int ADDR_W     = 12;
  localparam int MEM_REGION = 2048;
  localparam int IO_REGION  = 128;
  localparam int ACC_WIDTH  = 1;
  localparam int LEN_W      = 3;
  localparam int WILD_KIND  = 1;
  localparam int CNT_W      = 32;
  localparam int HDR_LEN    = 14;
  localparam int HDR_AW     = $clog2(HDR_LEN);
  localparam int HDR_SPAN   = 2 ** HDR_AW;
  localparam logic [7:0] MATCH_BYTE = 8'hFA;
  localparam logic [7:0] WILD_BYTE  = 8'hCE;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  function automatic addr_t trig_of(input int idx);
    int region;
    region = (idx < KINDS) ? MEM_REGION : IO_REGION;
    return addr_t'(region + idx * ACC_WIDTH);
  endfunction

  function automatic logic is_wild(input int idx);
    return (idx % KINDS) == WILD_KIND;
  endfunction
endpackage

// File: rtl/wht_select.sv
module wht_select
  import wht_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_io,
  input  addr_t       bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic        armed,
  output idx_t        arm_idx,
  output logic        arm_load
);
  logic sel_wr;
  logic in_range;
  logic armed_d;
  idx_t idx_d;

  assign sel_wr   = bus_wr && (bus_addr == '0);
  assign in_range = int'(bus_wdata) < KINDS;
  assign arm_load = sel_wr && in_range;

  always_comb begin
    armed_d = armed;
    idx_d   = arm_idx;
    if (sel_wr) begin
      armed_d = in_range;
      if (in_range)
        idx_d = idx_t'((bus_io ? KINDS : 0) + int'(bus_wdata));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      arm_idx <= '0;
    end else if (sel_wr) begin
      armed   <= armed_d;
      arm_idx <= idx_d;
    end
  end
endmodule

// File: rtl/wht_match.sv
module wht_match
  import wht_pkg::*;
(
  input  logic             armed,
  input  idx_t             arm_idx,
  input  logic             bus_wr,
  input  addr_t            bus_addr,
  input  logic [LEN_W-1:0] bus_len,
  input  logic [7:0]       bus_wdata,
  output addr_t            cur_trig,
  output logic             cur_wild,
  output logic             hit
);
  localparam int SLOTS = 2 ** IDX_W;

  addr_t trig_tbl [SLOTS];
  logic  wild_tbl [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_entry
    assign trig_tbl[g] = trig_of(g);
    assign wild_tbl[g] = is_wild(g);
  end

  logic data_ok;

  assign cur_trig = trig_tbl[arm_idx];
  assign cur_wild = wild_tbl[arm_idx];
  assign data_ok  = cur_wild ||
                    ((bus_len == LEN_W'(ACC_WIDTH)) && (bus_wdata == MATCH_BYTE));
  assign hit      = armed && bus_wr && (bus_addr != '0) &&
                    (bus_addr == cur_trig) && data_ok;
endmodule

// File: rtl/wht_counter.sv
module wht_counter
  import wht_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic inc,
  output cnt_t count
);
  cnt_t count_d;
  logic count_en;

  assign count_en = clear || inc;

  always_comb begin
    count_d = count + cnt_t'(1);
    if (clear) count_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (count_en) count <= count_d;
  end
endmodule

// File: rtl/wht_readback.sv
module wht_readback
  import wht_pkg::*;
(
  input  logic       armed,
  input  idx_t       arm_idx,
  input  addr_t      cur_trig,
  input  logic       cur_wild,
  input  cnt_t       hit_cnt,
  input  addr_t      bus_addr,
  output logic [7:0] bus_rdata
);
  logic [HDR_SPAN*8-1:0] hdr;
  logic [7:0]            exp_byte;
  logic [HDR_AW-1:0]     byte_sel;

  assign exp_byte = cur_wild ? WILD_BYTE : MATCH_BYTE;
  assign byte_sel = bus_addr[HDR_AW-1:0];
  assign hdr = {{((HDR_SPAN - HDR_LEN) * 8){1'b0}},
                hit_cnt,
                8'(ACC_WIDTH),
                exp_byte,
                32'(cur_trig),
                32'(arm_idx)};

  always_comb begin
    bus_rdata = '0;
    if (armed && (int'(bus_addr) < HDR_LEN))
      bus_rdata = hdr[{byte_sel, 3'b000} +: 8];
  end
endmodule

// File: rtl/wr_hit_target.sv
module wr_hit_target
  import wht_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_io,
  input  logic [11:0]      bus_addr,
  input  logic [2:0]       bus_len,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata
);
  logic  armed;
  idx_t  arm_idx;
  logic  arm_load;
  addr_t cur_trig;
  logic  cur_wild;
  logic  hit;
  cnt_t  hit_cnt;

  wht_select u_select (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_io    (bus_io),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .armed     (armed),
    .arm_idx   (arm_idx),
    .arm_load  (arm_load)
  );

  wht_match u_match (
    .armed     (armed),
    .arm_idx   (arm_idx),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_len   (bus_len),
    .bus_wdata (bus_wdata),
    .cur_trig  (cur_trig),
    .cur_wild  (cur_wild),
    .hit       (hit)
  );

  wht_counter u_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (arm_load),
    .inc   (hit),
    .count (hit_cnt)
  );

  wht_readback u_readback (
    .armed     (armed),
    .arm_idx   (arm_idx),
    .cur_trig  (cur_trig),
    .cur_wild  (cur_wild),
    .hit_cnt   (hit_cnt),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata)
  );
endmodule

// File: rtl/wht_checker.sv
module wht_checker
  import wht_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        bus_io,
  input logic [11:0] bus_addr,
  input logic [2:0]  bus_len,
  input logic [7:0]  bus_wdata,
  input logic [7:0]  bus_rdata,
  input logic        armed,
  input idx_t        arm_idx,
  input cnt_t        hit_cnt
);
  logic  sel_wr;
  logic  kind_ok;
  addr_t exp_trig;
  logic  exp_wild;
  int    exp_idx;

  assign sel_wr   = bus_wr && (bus_addr == 12'd0);
  assign kind_ok  = int'(bus_wdata) < KINDS;
  assign exp_trig = trig_of(int'(arm_idx));
  assign exp_wild = is_wild(int'(arm_idx));
  assign exp_idx  = (bus_io ? KINDS : 0) + int'(bus_wdata);

  assert_disarm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr && !kind_ok |=> !armed);

  assert_arm_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr && kind_ok |=> armed && (int'(arm_idx) == $past(exp_idx)));

  assert_arm_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr && kind_ok |=> hit_cnt == '0);

  assert_idle_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> bus_rdata == 8'h00);

  assert_idle_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !armed && !sel_wr |=> $stable(hit_cnt));

  assert_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    armed && bus_wr && !sel_wr && (bus_addr != exp_trig) |=> $stable(hit_cnt));

  assert_wild_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed && exp_wild && bus_wr && (bus_addr == exp_trig)
    |=> hit_cnt == $past(hit_cnt) + 32'd1);

  assert_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !exp_wild && bus_wr && !sel_wr &&
    ((bus_len != 3'd1) || (bus_wdata != MATCH_BYTE)) |=> $stable(hit_cnt));

  assert_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !sel_wr
    |=> (hit_cnt == $past(hit_cnt)) || (hit_cnt == $past(hit_cnt) + 32'd1));
endmodule

bind wr_hit_target wht_checker chk_i (.*);

// File: tb/wr_hit_target_tb_top.sv
module wr_hit_target_tb_top;
  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic        bus_io;
  logic [11:0] bus_addr;
  logic [2:0]  bus_len;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  wr_hit_target dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_io    (bus_io),
    .bus_addr  (bus_addr),
    .bus_len   (bus_len),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic        io;
    logic [11:0] addr;
    logic [2:0]  len;
    logic [7:0]  wdata;
    logic [11:0] raddr;
    logic [7:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 12'h000, 3'd1, 8'h00, 12'h000, 8'h00, 4'd2},  // R2 index 0
    '{1'b0, 1'b0, 12'h000, 3'd1, 8'h00, 12'h004, 8'h00, 4'd5},  // R5 trigger low
    '{1'b0, 1'b0, 12'h000, 3'd1, 8'h00, 12'h005, 8'h08, 4'd5},  // R5 trigger 0x800
    '{1'b1, 1'b0, 12'h800, 3'd1, 8'hFA, 12'h00A, 8'h01, 4'd6},  // R6 match
    '{1'b1, 1'b0, 12'h800, 3'd1, 8'hFB, 12'h00A, 8'h01, 4'd6},  // R6 bad data
    '{1'b1, 1'b0, 12'h800, 3'd2, 8'hFA, 12'h00A, 8'h01, 4'd6},  // R6 bad length
    '{1'b1, 1'b0, 12'h801, 3'd1, 8'hFA, 12'h00A, 8'h01, 4'd8},  // R8 other address
    '{1'b0, 1'b0, 12'h000, 3'd1, 8'h00, 12'h008, 8'hFA, 4'd6},  // R6 header byte
    '{1'b0, 1'b0, 12'h000, 3'd1, 8'h00, 12'h009, 8'h01, 4'd10}, // R10 width
    '{1'b0, 1'b0, 12'h000, 3'd1, 8'h00, 12'h00E, 8'h00, 4'd10}, // R10 past header
    '{1'b0, 1'b0, 12'h000, 3'd1, 8'h00, 12'h00D, 8'h00, 4'd12}, // R12 top byte
    '{1'b1, 1'b0, 12'h000, 3'd1, 8'h01, 12'h00A, 8'h00, 4'd4},  // R4 cleared
    '{1'b0, 1'b0, 12'h000, 3'd1, 8'h00, 12'h000, 8'h01, 4'd2},  // R2 index 1
    '{1'b0, 1'b0, 12'h000, 3'd1, 8'h00, 12'h008, 8'hCE, 4'd7},  // R7 header byte
    '{1'b1, 1'b0, 12'h801, 3'd4, 8'h33, 12'h00A, 8'h01, 4'd7},  // R7 any length
    '{1'b1, 1'b0, 12'h801, 3'd1, 8'h00, 12'h00A, 8'h02, 4'd7},  // R7 any data
    '{1'b1, 1'b1, 12'h000, 3'd1, 8'h02, 12'h000, 8'h05, 4'd1},  // R1 I/O select
    '{1'b0, 1'b1, 12'h000, 3'd1, 8'h00, 12'h004, 8'h85, 4'd5},  // R5 trigger 133
    '{1'b1, 1'b1, 12'h085, 3'd1, 8'hFA, 12'h00A, 8'h01, 4'd6},  // R6 I/O hit
    '{1'b1, 1'b0, 12'h085, 3'd1, 8'hFA, 12'h00A, 8'h02, 4'd1},  // R1 window ignored
    '{1'b1, 1'b1, 12'h000, 3'd1, 8'h00, 12'h004, 8'h83, 4'd5},  // R5 trigger 131
    '{1'b1, 1'b1, 12'h000, 3'd1, 8'h03, 12'h000, 8'h00, 4'd3},  // R3 disarm
    '{1'b1, 1'b1, 12'h083, 3'd1, 8'hFA, 12'h00A, 8'h00, 4'd9},  // R9 idle
    '{1'b1, 1'b0, 12'h000, 3'd1, 8'h02, 12'h004, 8'h02, 4'd5},  // R5 trigger 0x802
    '{1'b1, 1'b0, 12'h000, 3'd1, 8'hFF, 12'h000, 8'h00, 4'd3}   // R3 far out of range
  };

  task automatic write_byte(input logic io, input logic [11:0] a,
                            input logic [2:0] l, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_io = io; bus_addr = a; bus_len = l; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic check_read(input logic [11:0] a, input logic [7:0] exp,
                            input string tag);
    bus_wr   = 1'b0;
    bus_addr = a;
    #1;
    checks++;
    if (bus_rdata !== exp) begin
      fails++;
      $display("FAIL %s addr=0x%03h actual=0x%02h expected=0x%02h",
               tag, a, bus_rdata, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_io = 1'b0;
    bus_addr = '0; bus_len = 3'd1; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_read(12'h000, 8'h00, "R11 reset index");
    check_read(12'h00A, 8'h00, "R11 reset count");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr)
        write_byte(VEC[i].io, VEC[i].addr, VEC[i].len, VEC[i].wdata);
      else
        @(negedge clk);
      check_read(VEC[i].raddr, VEC[i].exp, $sformatf("R%0d vec%0d", VEC[i].req, i));
    end

    // R12: carry across counter bytes with 300 wildcard hits
    write_byte(1'b0, 12'h000, 3'd1, 8'h01);
    for (int k = 0; k < 300; k++) write_byte(1'b0, 12'h801, 3'd1, 8'h5A);
    check_read(12'h00A, 8'h2C, "R12 count byte0");
    check_read(12'h00B, 8'h01, "R12 count byte1");
    check_read(12'h00C, 8'h00, "R12 count byte2");

    // R11: reset while armed with hits
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_read(12'h008, 8'h00, "R11 disarmed after reset");
    write_byte(1'b0, 12'h000, 3'd1, 8'h01);
    check_read(12'h00A, 8'h00, "R11 count cleared");
    check_read(12'h00B, 8'h00, "R11 count cleared hi");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule